// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This peripheral holds a 16-bit up-count that software loads and reads one byte at a time. It advances on an internal instruction-cycle tick (timer mode) or on rising edges of an external clock pin (counter mode). The external clock may pass through a two-stage synchroniser, or it may be sampled raw for an asynchronous-style path with one cycle of latency. A prescaler divides the selected events by 1, 2, 4 or 8 before they reach the count. Software cannot see the prescaler. It clears whenever either count byte is written.

An optional gate lets counting run only while a chosen level is present. The source is either a gate pin or a comparator output bit, and the polarity is selectable, so the block can measure the high or the low interval of an external event. When the count wraps from FFFFh to 0000h it sets a sticky flag. The interrupt output asserts only when this flag and three enable bits are all set. In counter mode a falling edge must be seen after counting is enabled before any rising edge is accepted.

Register map (2-bit address): 0 is the low count byte, 1 is the high count byte, 2 is control, 3 is the interrupt register. The control bits are: bit0 run, bit1 external clock select, bit2 raw sampling, bit3 gate source, bits 5:4 prescale, bit6 gate enable, bit7 gate invert. The interrupt register holds bit0 flag, bit1 peripheral enable, bit2 group enable and bit3 global enable. Its upper bits read as zero.

Top module: `gtmr16_top`

## Requirements
- R1: Reset clears all four registers. Address 0 reads and writes count bits 7:0 and address 1 reads and writes bits 15:8. With control bit0=1, bit1=0 and the gate open, each cycle with tick_i high advances the count by one at prescale 1. Without a tick the count holds.
- R2: Control bits 5:4 with value p make the count advance once per 2^p qualifying events, starting from a cleared prescaler.
- R3: Any write to address 0 or 1 clears the prescaler. It also takes priority over an increment in the same cycle.
- R4: A step from FFFFh to 0000h sets interrupt-register bit0. The bit stays set until software writes 0 to it.
- R5: irq_o is high exactly when interrupt-register bits 0, 1, 2 and 3 are all set.
- R6: While control bit0 is 0, the count and the prescaler both hold their values, and counting resumes from them.
- R7: With control bit6=1, events count only while the selected gate (bit3=0 picks gate_pin_i, bit3=1 picks cmp_out_i) XOR bit7 is 1. At other times the count and prescaler freeze without resetting. With bit6=0 the gate inputs have no effect.
- R8: With control bit1=1, rising edges of ext_clk_i are counted and tick_i has no effect.
- R9: After run and external select both become set, the first rising edge of ext_clk_i counts only once a falling edge has been seen.
- R10: With bit1=1 and bit2=1, ext_clk_i and the gate are sampled raw, so a counted rising edge appears in the count after the first clock edge. With bit2=0 they pass through two synchroniser flops, so the count changes only after the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle tick used in timer mode |
| ext_clk_i | input | 1 | External count clock |
| gate_pin_i | input | 1 | Gate pin |
| cmp_out_i | input | 1 | Comparator output used as alternate gate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Timer mode is driven by random tick bursts at every prescale setting, combined with random gate source, polarity, enable and level, and with start values near the wrap point. This separates a wrong divide ratio, an inverted or misrouted gate, and a missed overflow flag. Counter mode is driven by pulse trains that begin at either level. A train that starts low must lose exactly its first rising edge and a train that starts high must lose none, which exposes a broken arming rule. Directed sequences cover the remaining cases. They write a count byte in the middle of a prescale period, stop and restart the run bit, and close the gate in the middle of a period. They also measure the one-edge versus three-edge latency that tells raw sampling from synchronised sampling.

// File: rtl/gtmr16_pkg.sv
package gtmr16_pkg;
   localparam int BYTE_W = 8;
   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      A_CNT_LO = 2'd0,
      A_CNT_HI = 2'd1,
      A_CTRL   = 2'd2,
      A_IRQ    = 2'd3
   } reg_addr_e;

   // control byte, MSB first
   typedef struct packed {
      logic       gate_inv;
      logic       gate_en;
      logic [1:0] ps;
      logic       gate_src;
      logic       async_sel;
      logic       ext_sel;
      logic       run;
   } ctrl_t;

   // interrupt nibble, MSB first
   typedef struct packed {
      logic glb_en;
      logic grp_en;
      logic per_en;
      logic flag;
   } irq_t;
endpackage

// File: rtl/gtmr16_sync.sv
module gtmr16_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gtmr16_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= {st_q[STAGES-2:0], d};
   end

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/gtmr16_src.sv
module gtmr16_src #(
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ext_clk_i,
   input  logic gate_pin_i,
   input  logic cmp_out_i,
   input  logic run_i,
   input  logic ext_sel_i,
   input  logic async_sel_i,
   input  logic gate_src_i,
   input  logic gate_en_i,
   input  logic gate_inv_i,
   output logic evt_o,
   output logic gate_open_o,
   output logic armed_o
);
   logic       gate_raw;
   logic [1:0] sync_q;
   logic       raw_mode;
   logic       ext_s, gate_s;
   logic       ext_d_q;
   logic       rise, fall;
   logic       armed_q;
   logic       src;

   assign gate_raw = gate_src_i ? cmp_out_i : gate_pin_i;

   gtmr16_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_clk_i, gate_raw}),
      .q     (sync_q)
   );

   if (ASYNC_EN) begin : g_raw
      assign raw_mode = ext_sel_i & async_sel_i;
   end else begin : g_noraw
      assign raw_mode = 1'b0;
   end

   assign ext_s  = raw_mode ? ext_clk_i : sync_q[1];
   assign gate_s = raw_mode ? gate_raw  : sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_d_q <= 1'b0;
      else        ext_d_q <= ext_s;
   end

   assign rise = ext_s & ~ext_d_q;
   assign fall = ~ext_s & ext_d_q;

   // a falling edge must be seen before rising edges are accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      armed_q <= 1'b0;
      else if (!(run_i && ext_sel_i))  armed_q <= 1'b0;
      else if (fall)                   armed_q <= 1'b1;
   end

   assign gate_open_o = ~gate_en_i | (gate_s ^ gate_inv_i);
   assign src         = ext_sel_i ? (rise & armed_q) : tick_i;
   assign evt_o       = run_i & gate_open_o & src;
   assign armed_o     = armed_q;
endmodule

// File: rtl/gtmr16_presc.sv
module gtmr16_presc #(
   parameter int PS_W        = 2,
   parameter bit PRESCALE_EN = 1'b1,
   localparam int PRE_W      = (1 << PS_W) - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            evt_i,
   input  logic [PS_W-1:0] ps_i,
   output logic            inc_o,
   output logic [PRE_W-1:0] pre_o
);
   if (PRESCALE_EN) begin : g_div
      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] last;
      logic             at_last;

      assign last    = PRE_W'((32'd1 << ps_i) - 32'd1);
      assign at_last = (pre_q == last);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pre_q <= '0;
         else if (clr_i)  pre_q <= '0;
         else if (evt_i)  pre_q <= at_last ? '0 : pre_q + 1'b1;
      end

      assign inc_o = evt_i & at_last & ~clr_i;
      assign pre_o = pre_q;
   end else begin : g_nodiv
      assign inc_o = evt_i & ~clr_i;
      assign pre_o = '0;
   end
endmodule

// File: rtl/gtmr16_top.sv
module gtmr16_top
   import gtmr16_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_EN    = 1'b1,
   parameter bit PRESCALE_EN = 1'b1,
   localparam int PRE_W      = (1 << PS_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ext_clk_i,
   input  logic              gate_pin_i,
   input  logic              cmp_out_i,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic              irq_o
);
   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("gtmr16_top: CNT_W must span exactly two bytes");
   end
   if (PS_W != 2) begin : g_bad_ps
      $error("gtmr16_top: control map holds a 2-bit prescale field");
   end

   ctrl_t            ctrl_q;
   irq_t             irq_q;
   logic [CNT_W-1:0] count_q;
   logic             wr_lo, wr_hi, wr_ctrl, wr_irq, cnt_wr;
   logic             evt, inc, wrap, gate_open, armed;
   logic [PRE_W-1:0] pre_q;

   assign wr_lo   = wr_en_i && (reg_addr_e'(addr_i) == A_CNT_LO);
   assign wr_hi   = wr_en_i && (reg_addr_e'(addr_i) == A_CNT_HI);
   assign wr_ctrl = wr_en_i && (reg_addr_e'(addr_i) == A_CTRL);
   assign wr_irq  = wr_en_i && (reg_addr_e'(addr_i) == A_IRQ);
   assign cnt_wr  = wr_lo | wr_hi;

   gtmr16_src #(.SYNC_STAGES(SYNC_STAGES), .ASYNC_EN(ASYNC_EN)) u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .ext_clk_i   (ext_clk_i),
      .gate_pin_i  (gate_pin_i),
      .cmp_out_i   (cmp_out_i),
      .run_i       (ctrl_q.run),
      .ext_sel_i   (ctrl_q.ext_sel),
      .async_sel_i (ctrl_q.async_sel),
      .gate_src_i  (ctrl_q.gate_src),
      .gate_en_i   (ctrl_q.gate_en),
      .gate_inv_i  (ctrl_q.gate_inv),
      .evt_o       (evt),
      .gate_open_o (gate_open),
      .armed_o     (armed)
   );

   gtmr16_presc #(.PS_W(PS_W), .PRESCALE_EN(PRESCALE_EN)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_wr),
      .evt_i (evt),
      .ps_i  (ctrl_q.ps),
      .inc_o (inc),
      .pre_o (pre_q)
   );

   assign wrap = inc & (&count_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (wr_lo) begin
         count_q[BYTE_W-1:0] <= wdata_i;
      end else if (wr_hi) begin
         count_q[CNT_W-1:BYTE_W] <= wdata_i;
      end else if (inc) begin
         count_q <= count_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= '0;
      end else begin
         if (wr_irq) irq_q <= irq_t'(wdata_i[3:0]);
         if (wrap)   irq_q.flag <= 1'b1;
      end
   end

   always_comb begin
      unique case (reg_addr_e'(addr_i))
         A_CNT_LO: rdata_o = count_q[BYTE_W-1:0];
         A_CNT_HI: rdata_o = count_q[CNT_W-1:BYTE_W];
         A_CTRL:   rdata_o = ctrl_q;
         default:  rdata_o = {{(BYTE_W-4){1'b0}}, irq_q};
      endcase
   end

   assign irq_o = irq_q.flag & irq_q.per_en & irq_q.grp_en & irq_q.glb_en;
endmodule

// File: rtl/gtmr16_chk.sv
module gtmr16_chk
   import gtmr16_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic [REG_AW-1:0] addr_i,
   input logic              irq_o,
   input logic              cnt_wr,
   input logic [CNT_W-1:0]  count_q,
   input logic [PRE_W-1:0]  pre_q,
   input logic              inc,
   input logic              flag,
   input logic              run,
   input logic              ext_sel,
   input logic              gate_en,
   input logic              gate_open,
   input logic              armed
);
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1))); // R1
   AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (pre_q == '0)); // R3
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && (&count_q) && !cnt_wr) |=> flag); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr_en_i && addr_i == 2'd3)) |=> flag); // R4
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !wr_en_i) |=> irq_o); // R5
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> ($stable(count_q) && $stable(pre_q))); // R6
   AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !gate_open && !cnt_wr) |=> ($stable(count_q) && $stable(pre_q))); // R7
   AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_sel && !armed && !cnt_wr) |=> $stable(count_q)); // R9
endmodule

bind gtmr16_top gtmr16_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_i   (wr_en_i),
   .addr_i    (addr_i),
   .irq_o     (irq_o),
   .cnt_wr    (cnt_wr),
   .count_q   (count_q),
   .pre_q     (pre_q),
   .inc       (inc),
   .flag      (irq_q.flag),
   .run       (ctrl_q.run),
   .ext_sel   (ctrl_q.ext_sel),
   .gate_en   (ctrl_q.gate_en),
   .gate_open (gate_open),
   .armed     (armed)
);

// File: tb/tb_gtmr16_top.sv
module tb_gtmr16_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, ext_clk_i = 1'b0, gate_pin_i = 1'b0, cmp_out_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic [7:0] wdata_i = 8'd0;
   logic [7:0] rdata_o;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gtmr16_top dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
      .gate_pin_i(gate_pin_i), .cmp_out_i(cmp_out_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
   );

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] v);
      addr_i = a;
      #1 v = rdata_o;
   endtask

   task automatic rd_cnt(output int v);
      logic [7:0] lo, hi;
      rd(2'd0, lo);
      rd(2'd1, hi);
      v = {16'd0, hi, lo};
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic pulses(int n, int hold);
      repeat (n) begin
         ext_clk_i = 1'b1; cyc(hold);
         ext_clk_i = 1'b0; cyc(hold);
      end
   endtask

   // stop, load count, clear interrupt register, then apply control
   task automatic setup(logic [7:0] ctrl, logic [15:0] start, logic [7:0] irqv);
      wr(2'd2, ctrl & 8'hFE);
      wr(2'd0, start[7:0]);
      wr(2'd1, start[15:8]);
      wr(2'd3, irqv);
      wr(2'd2, ctrl);
      cyc(4);
   endtask

   function automatic bit gate_ok(bit en, bit inv, bit sel, bit pin, bit cmp);
      return !en || (((sel ? cmp : pin) ^ inv) == 1'b1);
   endfunction

   initial begin
      int v;
      logic [7:0] b;
      void'($urandom(32'd20240611));
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], b);
         chk("R1", "reset register", b, 0);
      end
      chk("R5", "reset irq", irq_o, 0);

      // R1 timer basic
      setup(8'h01, 16'h1234, 8'h00);
      ticks(5);
      rd_cnt(v); chk("R1", "five ticks", v, 16'h1239);
      cyc(6);
      rd_cnt(v); chk("R1", "idle hold", v, 16'h1239);

      // R2 prescale ratios
      for (int p = 0; p < 4; p++) begin
         setup(8'h01 | 8'(p << 4), 16'h0000, 8'h00);
         ticks(12);
         rd_cnt(v); chk("R2", "prescale ratio", v, 12 >> p);
      end

      // R3 byte write clears prescaler
      setup(8'h21, 16'h0000, 8'h00);
      ticks(3);
      wr(2'd0, 8'h10);
      ticks(3);
      rd_cnt(v); chk("R3", "prescaler cleared by low write", v, 16'h0010);
      ticks(1);
      rd_cnt(v); chk("R3", "fourth tick after clear", v, 16'h0011);
      ticks(3);
      wr(2'd1, 8'hA5);
      ticks(3);
      rd_cnt(v); chk("R3", "prescaler cleared by high write", v, 16'hA511);

      // R4 wrap flag and stickiness
      setup(8'h01, 16'hFFFE, 8'h00);
      ticks(2);
      rd_cnt(v); chk("R4", "wrapped count", v, 0);
      rd(2'd3, b); chk("R4", "flag after wrap", b[0], 1);
      ticks(3);
      rd(2'd3, b); chk("R4", "flag sticky", b[0], 1);
      wr(2'd3, 8'h00);
      rd(2'd3, b); chk("R4", "flag cleared by software", b[0], 0);

      // R5 interrupt qualification
      setup(8'h01, 16'hFFFF, 8'h0E);
      chk("R5", "enables without flag", irq_o, 0);
      ticks(1);
      chk("R5", "irq after wrap", irq_o, 1);
      wr(2'd3, 8'h0D); chk("R5", "peripheral enable off", irq_o, 0);
      wr(2'd3, 8'h0B); chk("R5", "group enable off", irq_o, 0);
      wr(2'd3, 8'h07); chk("R5", "global enable off", irq_o, 0);
      wr(2'd3, 8'h0F); chk("R5", "all set", irq_o, 1);
      wr(2'd3, 8'h00);

      // R6 run bit holds count and prescaler
      setup(8'h21, 16'h0000, 8'h00);
      ticks(2);
      wr(2'd2, 8'h20);
      ticks(5);
      rd_cnt(v); chk("R6", "stopped count", v, 0);
      wr(2'd2, 8'h21);
      ticks(1);
      rd_cnt(v); chk("R6", "prescaler kept while stopped", v, 0);
      ticks(1);
      rd_cnt(v); chk("R6", "resumed count", v, 1);

      // R7 gate
      gate_pin_i = 1'b0;
      setup(8'h41, 16'h0000, 8'h00);
      ticks(5);
      rd_cnt(v); chk("R7", "pin gate closed", v, 0);
      gate_pin_i = 1'b1; cyc(4);
      ticks(3);
      rd_cnt(v); chk("R7", "pin gate open", v, 3);
      setup(8'hC1, 16'h0000, 8'h00);
      ticks(3);
      rd_cnt(v); chk("R7", "inverted gate closed", v, 0);
      gate_pin_i = 1'b0; cmp_out_i = 1'b1;
      setup(8'h49, 16'h0000, 8'h00);
      ticks(2);
      rd_cnt(v); chk("R7", "comparator gate open", v, 2);
      cmp_out_i = 1'b0;
      setup(8'h01, 16'h0000, 8'h00);
      ticks(2);
      rd_cnt(v); chk("R7", "gate ignored when disabled", v, 2);
      gate_pin_i = 1'b1;
      setup(8'h51, 16'h0000, 8'h00);
      ticks(1);
      gate_pin_i = 1'b0; cyc(4);
      ticks(3);
      rd_cnt(v); chk("R7", "gate freeze", v, 0);
      gate_pin_i = 1'b1; cyc(4);
      ticks(1);
      rd_cnt(v); chk("R7", "prescaler kept across gate", v, 1);
      gate_pin_i = 1'b0;

      // R8 / R9 external counting
      ext_clk_i = 1'b0;
      setup(8'h03, 16'h0000, 8'h00);
      ticks(4);
      rd_cnt(v); chk("R8", "tick ignored in counter mode", v, 0);
      pulses(5, 3); cyc(5);
      rd_cnt(v); chk("R9", "start low loses first rise", v, 4);
      ext_clk_i = 1'b1;
      setup(8'h03, 16'h0000, 8'h00);
      ext_clk_i = 1'b0; cyc(3);
      pulses(4, 3); cyc(5);
      rd_cnt(v); chk("R9", "start high counts all rises", v, 4);
      setup(8'h23, 16'h0000, 8'h00);
      pulses(9, 4); cyc(5);
      rd_cnt(v); chk("R8", "external with prescale 4", v, 2);

      // R10 sampling latency
      setup(8'h07, 16'h0000, 8'h00);
      pulses(1, 3);
      ext_clk_i = 1'b1; cyc(1);
      rd_cnt(v); chk("R10", "raw rise after one edge", v, 1);
      ext_clk_i = 1'b0; cyc(4);
      setup(8'h03, 16'h0000, 8'h00);
      pulses(1, 3);
      ext_clk_i = 1'b1; cyc(1);
      rd_cnt(v); chk("R10", "synced rise not after one edge", v, 0);
      cyc(1);
      rd_cnt(v); chk("R10", "synced rise not after two edges", v, 0);
      cyc(1);
      rd_cnt(v); chk("R10", "synced rise after three edges", v, 1);
      ext_clk_i = 1'b0; cyc(4);

      // random timer trials
      for (int t = 0; t < 40; t++) begin
         int unsigned p = $urandom % 4;
         bit en = 1'($urandom), inv = 1'($urandom), sel = 1'($urandom);
         bit runb = ($urandom % 5) != 0;
         int unsigned n = $urandom % 41;
         logic [15:0] start = ($urandom % 4 == 0) ? 16'hFFF0 | 16'($urandom % 16) : 16'($urandom);
         int exp_total, got_flag;
         gate_pin_i = 1'($urandom); cmp_out_i = 1'($urandom);
         setup({inv, en, 2'(p), sel, 2'b00, runb}, start, 8'h00);
         repeat (n) begin
            ticks(1);
            if ($urandom % 2) cyc(1);
         end
         exp_total = int'(start);
         if (runb && gate_ok(en, inv, sel, gate_pin_i, cmp_out_i)) exp_total += int'(n >> p);
         rd_cnt(v); chk("R2", "random timer count", v, exp_total & 16'hFFFF);
         rd(2'd3, b); got_flag = b[0];
         chk("R4", "random wrap flag", got_flag, (exp_total > 16'hFFFF) ? 1 : 0);
      end
      gate_pin_i = 1'b0; cmp_out_i = 1'b0;

      // random external trials
      for (int t = 0; t < 12; t++) begin
         int unsigned p = $urandom % 3;
         bit asy = 1'($urandom), hi_start = 1'($urandom);
         int unsigned n = $urandom % 11;
         int unsigned h = 3 + $urandom % 4;
         int counted;
         ext_clk_i = hi_start;
         setup({2'b00, 2'(p), 1'b0, asy, 2'b11}, 16'h0100, 8'h00);
         if (hi_start) begin ext_clk_i = 1'b0; cyc(h); end
         pulses(n, h); cyc(5);
         counted = hi_start ? int'(n) : ((n > 0) ? int'(n) - 1 : 0);
         rd_cnt(v); chk("R9", "random external count", v, 16'h0100 + (counted >> p));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule